// File: doc/BRIEF.md
# Interrupt Recognition and Acknowledge Sequencer

This block sits between the interrupt request lines of the peripherals and the core's exception logic. It takes a 3-bit, active-low encoded priority from the pins and passes it through a synchronizer. It compares the synchronized level with the current interrupt mask and keeps the highest request pending. The top level is treated differently: it cannot be masked, and it is registered only on a fresh rising transition into that level.

When the core raises its instruction-boundary strobe and reports no more urgent exception, the block starts an interrupt acknowledge cycle in CPU address space. During the cycle it drives the CPU-space function code, an all-ones address that carries the acknowledge type code and the level being serviced, and a bus request. At the start of the cycle it raises the mask to the serviced level. The device ends the cycle in one of two ways. It can place a vector number on the data lines, or it can ask for the automatic vector. The block then presents the resulting vector number for one cycle, together with a flag that tells which case occurred.

Top module: `irq_ack_seq`

## Requirements
- R1: After reset, bus_req is 0, fc is 3'b000, addr is 0, mask_out is 3'b111, irq_pending is 0 and vec_valid is 0.
- R2: The request pins pass through two synchronizer flops. A change on irq_pins_n does not affect irq_pending after one rising clock edge, and it is visible after the second edge.
- R3: For levels 1 to 6 (pins = bitwise inverse of the level, 3'b111 = no request), irq_pending is 1 and pend_level equals the level exactly when the level is strictly greater than mask_out. Otherwise irq_pending is 0 and pend_level is 0.
- R4: Level 7 (pins 3'b000) becomes pending only on a transition into 7 from a lower level, and this happens even when mask_out is 7. Holding the pins at 7 after that request has been acknowledged does not make it pending again.
- R5: An acknowledge starts only at a rising edge where boundary is 1, higher_exc is 0 and a request is pending. bus_req rises one clock later.
- R6: While the acknowledge is in progress, bus_req is 1 and fc is 3'b111. Outside it, fc is 3'b000.
- R7: During the acknowledge, addr has bits 19..16 = 4'b1111 (interrupt acknowledge type), bits 3..1 = the acknowledged level, bit 0 = 1, and every other bit = 1.
- R8: When the acknowledge starts, mask_out takes the acknowledged level.
- R9: If ack_done is sampled high with ack_auto low, the cycle ends. On the next cycle vec_valid pulses for one clock, vec_num holds data_in[7:0] and vec_auto is 0.
- R10: If ack_done is sampled high with ack_auto high, the cycle ends with vec_num = 24 + level and vec_auto = 1.
- R11: mask_load has no effect on mask_out while an acknowledge is in progress.
- R12: A latched level-7 request takes precedence over any lower pending level, both in pend_level and in the level acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins_n | input | 3 | Encoded priority request, active low |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| higher_exc | input | 1 | A more urgent exception is pending; defers the acknowledge |
| mask_load | input | 1 | Load mask_in into the mask (idle only) |
| mask_in | input | 3 | New mask value |
| ack_done | input | 1 | Device terminates the acknowledge cycle |
| ack_auto | input | 1 | Termination requests the automatic vector |
| data_in | input | 8 | Vector number from the device |
| bus_req | output | 1 | Acknowledge bus cycle in progress |
| fc | output | 3 | Function code, 3'b111 during acknowledge |
| addr | output | 32 | CPU-space acknowledge address |
| mask_out | output | 3 | Current interrupt mask |
| irq_pending | output | 1 | A request is pending |
| pend_level | output | 3 | Pending level, 0 when none |
| vec_valid | output | 1 | One-cycle pulse: vector result is valid |
| vec_num | output | 8 | Vector number |
| vec_auto | output | 1 | Result came from the automatic vector |

## Verification
Every combination of mask value 0 to 7 and request level 1 to 6 is applied, which separates a strict comparison from a greater-or-equal one at each mask. Levels 1 to 6 are each acknowledged, alternating between device-supplied and automatic termination, so the level field in the address, the mask update and the vector arithmetic are checked per level. Level 7 is driven at mask 7, held after its acknowledge, released and reasserted, which distinguishes edge detection from level sensing. A lower request arriving while a level-7 request is latched shows which of the two wins.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_IACK = 1'b1
  } seq_state_e;

  localparam logic [2:0] FC_CPU_SPACE  = 3'b111;
  localparam logic [2:0] FC_NONE       = 3'b000;
  localparam logic [3:0] CPU_TYPE_IACK = 4'b1111;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_n,
  output logic [W-1:0] level
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    for (int i = 0; i < STAGES; i++) begin
      if (i == 0) stg_d[i] = pins_n;
      else        stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{{W{1'b1}}}};
    else        stg_q <= stg_d;
  end

  // inversion sits after the last flop: active-low pins become a level
  assign level = ~stg_q[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] mask,
  input  logic         clr_top,
  output logic         pend_valid,
  output logic [W-1:0] pend_lvl
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] prev_q;
  logic         top_q;
  logic         top_d;
  logic         top_set;
  logic         low_hit;

  assign top_set = (level == TOP) && (prev_q != TOP);

  always_comb begin
    top_d = top_q;
    if (clr_top) top_d = 1'b0;
    if (top_set) top_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      top_q  <= 1'b0;
    end else begin
      prev_q <= level;
      top_q  <= top_d;
    end
  end

  // the top level enters only through the edge latch
  assign low_hit = (level != TOP) && (level > mask);

  always_comb begin
    if (top_q) begin
      pend_valid = 1'b1;
      pend_lvl   = TOP;
    end else if (low_hit) begin
      pend_valid = 1'b1;
      pend_lvl   = level;
    end else begin
      pend_valid = 1'b0;
      pend_lvl   = '0;
    end
  end
endmodule

// File: rtl/iack_fsm.sv
module iack_fsm
  import irq_pkg::*;
#(
  parameter int W         = 3,
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              higher_exc,
  input  logic              pend_valid,
  input  logic [W-1:0]      pend_lvl,
  input  logic              mask_load,
  input  logic [W-1:0]      mask_in,
  input  logic              ack_done,
  input  logic              ack_auto,
  input  logic [VEC_W-1:0]  data_in,
  output logic              start,
  output logic              bus_req,
  output logic [2:0]        fc,
  output logic [ADDR_W-1:0] addr,
  output logic [W-1:0]      mask,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_num,
  output logic              vec_auto
);
  localparam int TYPE_LSB = 16;

  seq_state_e       state_q, state_d;
  logic [W-1:0]     lvl_q, mask_q, mask_d;
  logic             mask_en;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             auto_q, vvalid_q;
  logic             finish;

  assign start  = (state_q == SEQ_IDLE) && boundary && !higher_exc && pend_valid;
  assign finish = (state_q == SEQ_IACK) && ack_done;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE: if (start)  state_d = SEQ_IACK;
      SEQ_IACK: if (finish) state_d = SEQ_IDLE;
      default:              state_d = SEQ_IDLE;
    endcase
  end

  always_comb begin
    mask_en = 1'b0;
    mask_d  = mask_q;
    if (start) begin
      mask_en = 1'b1;
      mask_d  = pend_lvl;
    end else if ((state_q == SEQ_IDLE) && mask_load) begin
      mask_en = 1'b1;
      mask_d  = mask_in;
    end
  end

  assign vec_d = ack_auto ? (VEC_W'(AUTO_BASE) + VEC_W'(lvl_q)) : data_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      lvl_q    <= '0;
      mask_q   <= {W{1'b1}};
      vec_q    <= '0;
      auto_q   <= 1'b0;
      vvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      vvalid_q <= finish;
      if (start)   lvl_q  <= pend_lvl;
      if (mask_en) mask_q <= mask_d;
      if (finish) begin
        vec_q  <= vec_d;
        auto_q <= ack_auto;
      end
    end
  end

  always_comb begin
    bus_req = (state_q == SEQ_IACK);
    fc      = bus_req ? FC_CPU_SPACE : FC_NONE;
    addr    = '0;
    if (bus_req) begin
      addr = {ADDR_W{1'b1}};
      addr[TYPE_LSB +: 4] = CPU_TYPE_IACK;
      addr[W:1] = lvl_q;
      addr[0]   = 1'b1;
    end
  end

  assign mask      = mask_q;
  assign vec_valid = vvalid_q;
  assign vec_num   = vec_q;
  assign vec_auto  = auto_q;
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int PRIO_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 32,
  parameter int VEC_W       = 8,
  parameter int AUTO_BASE   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRIO_W-1:0] irq_pins_n,
  input  logic              boundary,
  input  logic              higher_exc,
  input  logic              mask_load,
  input  logic [PRIO_W-1:0] mask_in,
  input  logic              ack_done,
  input  logic              ack_auto,
  input  logic [VEC_W-1:0]  data_in,
  output logic              bus_req,
  output logic [2:0]        fc,
  output logic [ADDR_W-1:0] addr,
  output logic [PRIO_W-1:0] mask_out,
  output logic              irq_pending,
  output logic [PRIO_W-1:0] pend_level,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_num,
  output logic              vec_auto
);
  logic [PRIO_W-1:0] sync_lvl;
  logic              start;

  irq_sync #(.W(PRIO_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_n (irq_pins_n),
    .level  (sync_lvl)
  );

  irq_pend #(.W(PRIO_W)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (sync_lvl),
    .mask       (mask_out),
    .clr_top    (start),
    .pend_valid (irq_pending),
    .pend_lvl   (pend_level)
  );

  iack_fsm #(
    .W(PRIO_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W), .AUTO_BASE(AUTO_BASE)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .higher_exc (higher_exc),
    .pend_valid (irq_pending),
    .pend_lvl   (pend_level),
    .mask_load  (mask_load),
    .mask_in    (mask_in),
    .ack_done   (ack_done),
    .ack_auto   (ack_auto),
    .data_in    (data_in),
    .start      (start),
    .bus_req    (bus_req),
    .fc         (fc),
    .addr       (addr),
    .mask       (mask_out),
    .vec_valid  (vec_valid),
    .vec_num    (vec_num),
    .vec_auto   (vec_auto)
  );
endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk #(
  parameter int PRIO_W    = 3,
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary,
  input logic              higher_exc,
  input logic              ack_done,
  input logic              bus_req,
  input logic [2:0]        fc,
  input logic [ADDR_W-1:0] addr,
  input logic [PRIO_W-1:0] mask_out,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vec_num,
  input logic              vec_auto
);
  AST_FC_CPU_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> fc == 3'b111); // R6
  AST_FC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> fc == 3'b000); // R6
  AST_ADDR_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (addr[19:16] == 4'b1111) && addr[0] && (addr[ADDR_W-1:20] == '1)); // R7
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(boundary) && !$past(higher_exc)); // R5
  AST_MASK_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> mask_out == addr[PRIO_W:1]); // R8
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> $stable(mask_out)); // R11
  AST_VEC_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack_done) && $past(bus_req)); // R9
  AST_AUTO_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_auto) |-> vec_num == VEC_W'(AUTO_BASE) + VEC_W'($past(addr[PRIO_W:1]))); // R10
endmodule

bind irq_ack_seq irq_ack_seq_chk #(
  .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W), .AUTO_BASE(AUTO_BASE)
) u_chk (.*);

// File: tb/test_irq_ack_seq.sv
module test_irq_ack_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  irq_pins_n;
  logic        boundary, higher_exc, mask_load, ack_done, ack_auto;
  logic [2:0]  mask_in;
  logic [7:0]  data_in;
  logic        bus_req, irq_pending, vec_valid, vec_auto;
  logic [2:0]  fc, mask_out, pend_level;
  logic [31:0] addr;
  logic [7:0]  vec_num;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ack_seq i_irq_ack_seq (
    .clk(clk), .rst_n(rst_n), .irq_pins_n(irq_pins_n), .boundary(boundary),
    .higher_exc(higher_exc), .mask_load(mask_load), .mask_in(mask_in),
    .ack_done(ack_done), .ack_auto(ack_auto), .data_in(data_in),
    .bus_req(bus_req), .fc(fc), .addr(addr), .mask_out(mask_out),
    .irq_pending(irq_pending), .pend_level(pend_level),
    .vec_valid(vec_valid), .vec_num(vec_num), .vec_auto(vec_auto)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mask(input logic [2:0] m);
    mask_load = 1'b1; mask_in = m;
    cyc(1);
    mask_load = 1'b0;
  endtask

  function automatic logic [31:0] iack_addr(input int lvl);
    return 32'hFFFF_FFF1 | (32'(lvl) << 1);
  endfunction

  initial begin
    int cnt = 0;
    while (!done && cnt < WATCHDOG) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cnt);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    irq_pins_n = 3'b111; boundary = 0; higher_exc = 0; mask_load = 0;
    mask_in = 0; ack_done = 0; ack_auto = 0; data_in = 0; rst_n = 0;
    cyc(3);
    rst_n = 1;
    cyc(1);

    // R1 reset state
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 fc", 32'(fc), 0);
    chk("R1 addr", addr, 0);
    chk("R1 mask", 32'(mask_out), 7);
    chk("R1 pending", 32'(irq_pending), 0);
    chk("R1 vec_valid", 32'(vec_valid), 0);

    // R3 sweep of mask against levels 1..6
    for (int m = 0; m < 8; m++) begin
      set_mask(3'(m));
      for (int l = 1; l < 7; l++) begin
        irq_pins_n = ~3'(l);
        cyc(3);
        chk($sformatf("R3 pending m%0d l%0d", m, l), 32'(irq_pending), 32'(l > m));
        chk($sformatf("R3 level m%0d l%0d", m, l), 32'(pend_level), (l > m) ? 32'(l) : 0);
      end
      irq_pins_n = 3'b111;
      cyc(3);
    end

    // R2 synchronizer latency
    set_mask(3'd0);
    irq_pins_n = ~3'd5;
    cyc(1);
    chk("R2 after one edge", 32'(irq_pending), 0);
    cyc(1);
    chk("R2 after two edges", 32'(irq_pending), 1);
    chk("R2 level", 32'(pend_level), 5);
    irq_pins_n = 3'b111;
    cyc(3);

    // R5..R11 acknowledge of each level, alternating termination
    for (int l = 1; l < 7; l++) begin
      bit au = l[0];
      set_mask(3'd0);
      irq_pins_n = ~3'(l);
      cyc(3);
      if (l == 1) begin
        higher_exc = 1; boundary = 1;
        cyc(1);
        chk("R5 deferred by higher exception", 32'(bus_req), 0);
        higher_exc = 0; boundary = 0;
        cyc(1);
        chk("R5 no start without boundary", 32'(bus_req), 0);
      end
      boundary = 1;
      cyc(1);
      boundary = 0;
      chk($sformatf("R5 start l%0d", l), 32'(bus_req), 1);
      chk($sformatf("R6 fc l%0d", l), 32'(fc), 7);
      chk($sformatf("R7 addr l%0d", l), addr, iack_addr(l));
      chk($sformatf("R8 mask l%0d", l), 32'(mask_out), 32'(l));
      mask_load = 1; mask_in = 3'd0;
      cyc(1);
      mask_load = 0;
      chk($sformatf("R11 mask held l%0d", l), 32'(mask_out), 32'(l));
      ack_auto = au; data_in = 8'h40 + 8'(l); ack_done = 1;
      cyc(1);
      ack_done = 0; ack_auto = 0;
      chk($sformatf("R9 vec_valid l%0d", l), 32'(vec_valid), 1);
      if (au) begin
        chk($sformatf("R10 vector l%0d", l), 32'(vec_num), 32'(24 + l));
        chk($sformatf("R10 flag l%0d", l), 32'(vec_auto), 1);
      end else begin
        chk($sformatf("R9 vector l%0d", l), 32'(vec_num), 32'h40 + 32'(l));
        chk($sformatf("R9 flag l%0d", l), 32'(vec_auto), 0);
      end
      chk($sformatf("R6 idle fc l%0d", l), 32'(fc), 0);
      chk($sformatf("R11 mask after l%0d", l), 32'(mask_out), 32'(l));
      cyc(1);
      chk($sformatf("R9 pulse l%0d", l), 32'(vec_valid), 0);
      irq_pins_n = 3'b111;
      cyc(3);
    end

    // R4 level 7 edge, unmaskable
    set_mask(3'd7);
    irq_pins_n = 3'b000;
    cyc(4);
    chk("R4 pending at mask 7", 32'(irq_pending), 1);
    chk("R4 level", 32'(pend_level), 7);
    boundary = 1;
    cyc(1);
    boundary = 0;
    chk("R7 addr level 7", addr, 32'hFFFF_FFFF);
    data_in = 8'h99; ack_done = 1;
    cyc(1);
    ack_done = 0;
    chk("R9 vector level 7", 32'(vec_num), 32'h99);
    cyc(6);
    chk("R4 no retrigger while held", 32'(irq_pending), 0);
    irq_pins_n = 3'b111;
    cyc(3);
    irq_pins_n = 3'b000;
    cyc(4);
    chk("R4 new edge pends", 32'(irq_pending), 1);

    // R12 latched level 7 beats a lower level
    set_mask(3'd0);
    irq_pins_n = ~3'd3;
    cyc(3);
    chk("R12 level while latched", 32'(pend_level), 7);
    boundary = 1;
    cyc(1);
    boundary = 0;
    chk("R12 acknowledged level", addr, 32'hFFFF_FFFF);
    ack_done = 1; ack_auto = 1;
    cyc(1);
    ack_done = 0; ack_auto = 0;
    chk("R10 vector level 7", 32'(vec_num), 31);
    chk("R3 level 3 under mask 7", 32'(irq_pending), 0);
    set_mask(3'd0);
    cyc(1);
    chk("R12 lower level after release", 32'(pend_level), 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule